// File: doc/BRIEF.md
# Two-Level Page Translator

This block turns guest-side page addresses into host addresses. It walks a two-level table: a top-level index picks a second-level block, and a leaf index picks an entry within that block. Each entry holds either the page-aligned host base address or one of two sentinel codes. All ones marks a page as unmapped. All ones with bit 0 cleared marks a page as reserved, meaning it is claimed but has no host target yet. A second-level block that has never been written reads as unmapped. On the first write into a block, every other entry of that block is set to unmapped.

A lookup port translates one address per request, with one cycle of latency. A command port carries four operations:

- reserve a run of pages anywhere, using a first-fit search with an alignment;
- reserve a run of pages at a given address;
- map a host range anywhere, using a first-fit search;
- map a host range onto pages reserved earlier.

A fixed-address request whose range fails its precondition falls back to the matching first-fit search. Each operation ends with a single response beat that gives a found flag and the base page address.

The page offset width, the leaf index width, the top index width and the host width are all parameters. The defaults give 256 pages of 4 KiB.

Top module: `pgx_translator`

## Requirements
- R1: After reset, op_ready is 1, rsp_valid is 0 and lk_done is 0, and every lookup reports a fault.
- R2: lk_done rises exactly one cycle after a cycle with lk_valid high and is low otherwise. For a mapped page, lk_haddr equals the entry's host base plus the low PAGE_BITS bits of lk_gaddr, and lk_fault is 0.
- R3: A lookup of an unmapped or reserved page sets lk_fault to 1 and returns lk_haddr of 0. Pages whose second-level block was never written, and the untouched neighbours of a written page, read as unmapped.
- R4: Map-at (op_kind 3) checks whether every page in the range is reserved. If so, it writes page i with (op_haddr aligned down to a page) plus i pages, and responds found=1 with rsp_gaddr set to the requested page address.
- R5: Map-at falls back to map-anywhere when any page in its range is not reserved or the range runs past the last page.
- R6: Reserve-at (op_kind 1) checks whether every page in the range is unmapped. If so, it marks those pages reserved and responds with the requested page address. Otherwise it falls back to reserve-anywhere with the same alignment.
- R7: Reserve-anywhere (op_kind 0) is a first-fit search.
  - The first candidate is page 0.
  - When page p is found not unmapped, the next candidate is p+1 rounded up to a multiple of 2^op_align_log2 pages.
  - An alignment exponent above LEAF_BITS+TOP_BITS is clamped to that value.
  - The result is the first candidate followed by op_pages unmapped pages.
- R8: Map-anywhere (op_kind 2) runs the same first-fit search with one-page alignment, then fills the run with consecutive host pages.
- R9: If the scan reaches the page count 2^(LEAF_BITS+TOP_BITS), the response has found=0 and rsp_gaddr=0, and no entry changes.
- R10: op_ready is high only while idle, and a request is taken only when op_ready is high. Each accepted request gives exactly one rsp_valid pulse, after which op_ready returns. op_valid while op_ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_gaddr | input | GA_W | Address to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_fault | output | 1 | Page unmapped or reserved |
| lk_haddr | output | HOST_W | Translated host address (0 on fault) |
| op_valid | input | 1 | Command request |
| op_ready | output | 1 | Command port idle |
| op_kind | input | 2 | 0 reserve-any, 1 reserve-at, 2 map-any, 3 map-at |
| op_gaddr | input | GA_W | Target page address for the fixed-address kinds |
| op_haddr | input | HOST_W | Host base for the map kinds |
| op_pages | input | CNT_W | Run length in pages |
| op_align_log2 | input | ALN_W | Log2 of the reservation alignment in pages |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_found | output | 1 | A run was placed |
| rsp_gaddr | output | GA_W | Base address of the placed run |

## Verification
The properties assume op_pages is at least one. With a zero count the scan never completes a run, so only the not-found path would ever answer. They also assume lookups are not issued while a fill is writing the same page. The stimulus keeps every request count between 1 and 300 and runs lookup sweeps only between commands. A bench model of the table predicts each placement from the first-fit rule. After each command, a full sweep over all pages compares every translated address or fault.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        OP_RESV_ANY = 2'd0,
        OP_RESV_AT  = 2'd1,
        OP_MAP_ANY  = 2'd2,
        OP_MAP_AT   = 2'd3
    } pgx_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEARCH,
        ST_FILL,
        ST_RESP
    } pgx_state_e;

    // Round v up to a multiple of 2**lg.
    function automatic int unsigned pgx_align_up(int unsigned v, int unsigned lg);
        int unsigned mask;
        mask = (32'd1 << lg) - 32'd1;
        return (v + mask) & ~mask;
    endfunction

    function automatic int unsigned pgx_clamp_log(int unsigned lg, int unsigned max_lg);
        return (lg > max_lg) ? max_lg : lg;
    endfunction

    function automatic logic pgx_is_map(pgx_op_e k);
        return (k == OP_MAP_ANY) || (k == OP_MAP_AT);
    endfunction

    function automatic logic pgx_is_fixed(pgx_op_e k);
        return (k == OP_RESV_AT) || (k == OP_MAP_AT);
    endfunction

endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int LEAF_BITS = 4,
    parameter int TOP_BITS  = 4,
    parameter int HOST_W    = 40,
    parameter int NRD       = 2,
    localparam int PIDX_W   = LEAF_BITS + TOP_BITS,
    localparam int NTOP     = 1 << TOP_BITS,
    localparam int NLEAF    = 1 << LEAF_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [PIDX_W-1:0]             wr_page,
    input  logic [HOST_W-1:0]             wr_data,
    input  logic [NRD-1:0][PIDX_W-1:0]    rd_page,
    output logic [NRD-1:0][HOST_W-1:0]    rd_data
);
    localparam logic [HOST_W-1:0] ENT_UNM = '1;

    logic [NTOP-1:0]   present;
    logic [HOST_W-1:0] leaf [NTOP][NLEAF];

    logic [TOP_BITS-1:0]  w_top;
    logic [LEAF_BITS-1:0] w_leaf;
    assign w_top  = wr_page[PIDX_W-1:LEAF_BITS];
    assign w_leaf = wr_page[LEAF_BITS-1:0];

    // Top level: a block is attached on its first write.
    always_ff @(posedge clk) begin
        if (rst) begin
            present <= '0;
        end else if (wr_en) begin
            present[w_top] <= 1'b1;
        end
    end

    // Second level: the first write into a block also clears its siblings.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < NLEAF; l++) begin
                if (LEAF_BITS'(l) == w_leaf) begin
                    leaf[w_top][l] <= wr_data;
                end else if (!present[w_top]) begin
                    leaf[w_top][l] <= ENT_UNM;
                end
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        logic [TOP_BITS-1:0]  r_top;
        logic [LEAF_BITS-1:0] r_leaf;
        assign r_top      = rd_page[r][PIDX_W-1:LEAF_BITS];
        assign r_leaf     = rd_page[r][LEAF_BITS-1:0];
        assign rd_data[r] = present[r_top] ? leaf[r_top][r_leaf] : ENT_UNM;
    end

endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup #(
    parameter int PAGE_BITS = 12,
    parameter int PIDX_W    = 8,
    parameter int HOST_W    = 40,
    localparam int GA_W     = PAGE_BITS + PIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [GA_W-1:0]   lk_gaddr,
    output logic [PIDX_W-1:0] tbl_page,
    input  logic [HOST_W-1:0] tbl_entry,
    output logic              lk_done,
    output logic              lk_fault,
    output logic [HOST_W-1:0] lk_haddr
);
    logic [PAGE_BITS-1:0] offset;
    logic                 sentinel;

    assign tbl_page = PIDX_W'(lk_gaddr >> PAGE_BITS);
    assign offset   = lk_gaddr[PAGE_BITS-1:0];
    // Both sentinels share all ones above bit 0.
    assign sentinel = &tbl_entry[HOST_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done  <= 1'b0;
            lk_fault <= 1'b0;
            lk_haddr <= '0;
        end else begin
            lk_done <= lk_valid;
            if (lk_valid) begin
                lk_fault <= sentinel;
                lk_haddr <= sentinel ? '0 : tbl_entry + HOST_W'(offset);
            end
        end
    end

endmodule

// File: rtl/pgx_seq.sv
module pgx_seq
    import pgx_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int PIDX_W    = 8,
    parameter int HOST_W    = 40,
    localparam int GA_W     = PAGE_BITS + PIDX_W,
    localparam int CNT_W    = PIDX_W + 1,
    localparam int ALN_W    = $clog2(PIDX_W + 1),
    localparam int SUM_W    = CNT_W + 1,
    localparam int NPAGE    = 1 << PIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [GA_W-1:0]   op_gaddr,
    input  logic [HOST_W-1:0] op_haddr,
    input  logic [CNT_W-1:0]  op_pages,
    input  logic [ALN_W-1:0]  op_align_log2,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [GA_W-1:0]   rsp_gaddr,
    output logic [PIDX_W-1:0] rd_page,
    input  logic [HOST_W-1:0] rd_data,
    output logic              wr_en,
    output logic [PIDX_W-1:0] wr_page,
    output logic [HOST_W-1:0] wr_data
);
    localparam logic [HOST_W-1:0] ENT_UNM  = '1;
    localparam logic [HOST_W-1:0] ENT_RSV  = {{(HOST_W-1){1'b1}}, 1'b0};
    localparam logic [HOST_W-1:0] OFF_MASK = {{(HOST_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

    pgx_state_e        state;
    pgx_op_e           kind;
    pgx_op_e           in_kind;
    logic [CNT_W-1:0]  cand, cnt, need_cnt, ptr;
    logic [ALN_W-1:0]  alog;
    logic [HOST_W-1:0] hbase;
    logic              found;

    logic [SUM_W-1:0]  scan_p;
    logic              past_end, last_hit, fill_last;
    logic [HOST_W-1:0] want;
    logic [CNT_W-1:0]  next_cand, fill_sum;

    assign in_kind   = pgx_op_e'(op_kind);
    assign scan_p    = SUM_W'(cand) + SUM_W'(cnt);
    assign past_end  = scan_p >= SUM_W'(NPAGE);
    assign last_hit  = (cnt + CNT_W'(1)) == need_cnt;
    assign fill_last = (ptr + CNT_W'(1)) == need_cnt;
    assign want      = (kind == OP_RESV_AT) ? ENT_UNM : ENT_RSV;
    assign next_cand = CNT_W'(pgx_align_up(32'(scan_p) + 32'd1, 32'(alog)));
    assign fill_sum  = cand + ptr;

    assign rd_page   = scan_p[PIDX_W-1:0];
    assign wr_en     = (state == ST_FILL);
    assign wr_page   = fill_sum[PIDX_W-1:0];
    assign wr_data   = pgx_is_map(kind) ? hbase + (HOST_W'(ptr) << PAGE_BITS) : ENT_RSV;

    assign op_ready  = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_found = found;
    assign rsp_gaddr = found ? (GA_W'(cand[PIDX_W-1:0]) << PAGE_BITS) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= OP_RESV_ANY;
            cand     <= '0;
            cnt      <= '0;
            need_cnt <= '0;
            ptr      <= '0;
            alog     <= '0;
            hbase    <= '0;
            found    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (op_valid) begin
                        kind     <= in_kind;
                        need_cnt <= op_pages;
                        alog     <= pgx_is_map(in_kind) ? '0 :
                                    ALN_W'(pgx_clamp_log(32'(op_align_log2), PIDX_W));
                        hbase    <= op_haddr & ~OFF_MASK;
                        cnt      <= '0;
                        ptr      <= '0;
                        found    <= 1'b0;
                        if (pgx_is_fixed(in_kind)) begin
                            cand  <= CNT_W'(op_gaddr >> PAGE_BITS);
                            state <= ST_CHECK;
                        end else begin
                            cand  <= '0;
                            state <= ST_SEARCH;
                        end
                    end
                end
                ST_CHECK: begin
                    if (past_end || rd_data != want) begin
                        cand  <= '0;
                        cnt   <= '0;
                        state <= ST_SEARCH;
                    end else if (last_hit) begin
                        ptr   <= '0;
                        state <= ST_FILL;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SEARCH: begin
                    if (past_end) begin
                        found <= 1'b0;
                        state <= ST_RESP;
                    end else if (rd_data == ENT_UNM) begin
                        if (last_hit) begin
                            ptr   <= '0;
                            state <= ST_FILL;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end else begin
                        cand <= next_cand;
                        cnt  <= '0;
                    end
                end
                ST_FILL: begin
                    ptr <= ptr + CNT_W'(1);
                    if (fill_last) begin
                        found <= 1'b1;
                        state <= ST_RESP;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int LEAF_BITS = 4,
    parameter int TOP_BITS  = 4,
    parameter int HOST_W    = 40,
    localparam int PIDX_W   = LEAF_BITS + TOP_BITS,
    localparam int GA_W     = PAGE_BITS + PIDX_W,
    localparam int CNT_W    = PIDX_W + 1,
    localparam int ALN_W    = $clog2(PIDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [GA_W-1:0]   lk_gaddr,
    output logic              lk_done,
    output logic              lk_fault,
    output logic [HOST_W-1:0] lk_haddr,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_kind,
    input  logic [GA_W-1:0]   op_gaddr,
    input  logic [HOST_W-1:0] op_haddr,
    input  logic [CNT_W-1:0]  op_pages,
    input  logic [ALN_W-1:0]  op_align_log2,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [GA_W-1:0]   rsp_gaddr
);
    localparam int PORT_LK  = 0;
    localparam int PORT_SEQ = 1;

    logic [1:0][PIDX_W-1:0] rd_page;
    logic [1:0][HOST_W-1:0] rd_data;
    logic                   wr_en;
    logic [PIDX_W-1:0]      wr_page;
    logic [HOST_W-1:0]      wr_data;

    pgx_table #(
        .LEAF_BITS(LEAF_BITS), .TOP_BITS(TOP_BITS), .HOST_W(HOST_W), .NRD(2)
    ) table_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_page(wr_page), .wr_data(wr_data),
        .rd_page(rd_page), .rd_data(rd_data)
    );

    pgx_lookup #(
        .PAGE_BITS(PAGE_BITS), .PIDX_W(PIDX_W), .HOST_W(HOST_W)
    ) lookup_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_gaddr(lk_gaddr),
        .tbl_page(rd_page[PORT_LK]), .tbl_entry(rd_data[PORT_LK]),
        .lk_done(lk_done), .lk_fault(lk_fault), .lk_haddr(lk_haddr)
    );

    pgx_seq #(
        .PAGE_BITS(PAGE_BITS), .PIDX_W(PIDX_W), .HOST_W(HOST_W)
    ) seq_i (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_gaddr(op_gaddr), .op_haddr(op_haddr), .op_pages(op_pages),
        .op_align_log2(op_align_log2),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_gaddr(rsp_gaddr),
        .rd_page(rd_page[PORT_SEQ]), .rd_data(rd_data[PORT_SEQ]),
        .wr_en(wr_en), .wr_page(wr_page), .wr_data(wr_data)
    );

endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
    parameter int PAGE_BITS = 12,
    parameter int GA_W      = 20,
    parameter int HOST_W    = 40
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lk_valid,
    input logic [PAGE_BITS-1:0] lk_off,
    input logic                 lk_done,
    input logic                 lk_fault,
    input logic [HOST_W-1:0]    lk_haddr,
    input logic                 op_valid,
    input logic                 op_ready,
    input logic                 rsp_valid,
    input logic                 rsp_found,
    input logic [GA_W-1:0]      rsp_gaddr
);
    // R2
    lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    // R2
    lookup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    // R2
    offset_carry_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (lk_fault || lk_haddr[PAGE_BITS-1:0] == $past(lk_off)));

    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_done && lk_fault) |-> lk_haddr == '0);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready) |=> !op_ready);

    // R10
    idle_after_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (op_ready && !rsp_valid));

    // R10
    resp_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !op_ready);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_found) |-> rsp_gaddr == '0);

    // R7
    base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_found) |-> rsp_gaddr[PAGE_BITS-1:0] == '0);

endmodule

bind pgx_translator pgx_checker #(
    .PAGE_BITS(PAGE_BITS), .GA_W(GA_W), .HOST_W(HOST_W)
) chk_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_off(lk_gaddr[PAGE_BITS-1:0]),
    .lk_done(lk_done), .lk_fault(lk_fault), .lk_haddr(lk_haddr),
    .op_valid(op_valid), .op_ready(op_ready),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_gaddr(rsp_gaddr)
);

// File: tb/pgx_translator_tb_top.sv
`timescale 1ns/1ps
module pgx_translator_tb_top;
    localparam int PB = 12;
    localparam int PW = 8;
    localparam int GW = PB + PW;
    localparam int HW = 40;
    localparam int NP = 1 << PW;
    localparam int CW = PW + 1;
    localparam int AW = 4;
    localparam logic [HW-1:0] UNM = '1;
    localparam logic [HW-1:0] RSV = {{(HW-1){1'b1}}, 1'b0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [GW-1:0] lk_gaddr = '0;
    logic          lk_done, lk_fault;
    logic [HW-1:0] lk_haddr;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_kind = '0;
    logic [GW-1:0] op_gaddr = '0;
    logic [HW-1:0] op_haddr = '0;
    logic [CW-1:0] op_pages = '0;
    logic [AW-1:0] op_align_log2 = '0;
    logic          rsp_valid, rsp_found;
    logic [GW-1:0] rsp_gaddr;

    always #2 clk = ~clk;

    pgx_translator dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_gaddr(lk_gaddr),
        .lk_done(lk_done), .lk_fault(lk_fault), .lk_haddr(lk_haddr),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_gaddr(op_gaddr), .op_haddr(op_haddr), .op_pages(op_pages),
        .op_align_log2(op_align_log2),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_gaddr(rsp_gaddr)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [HW-1:0] mdl [NP];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input int pg, input int off, input string req);
        logic          ef;
        logic [HW-1:0] eh;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_gaddr = (GW'(pg) << PB) | GW'(off);
        @(negedge clk);
        lk_valid = 1'b0;
        ef = (mdl[pg] == UNM) || (mdl[pg] == RSV);
        eh = ef ? '0 : mdl[pg] + HW'(off);
        chk(lk_done && lk_fault == ef && lk_haddr == eh, req, "lookup",
            {lk_done, lk_fault, 2'b0, 20'(pg), lk_haddr}, {1'b1, ef, 2'b0, 20'(pg), eh});
    endtask

    task automatic sweep(input string req);
        for (int p = 0; p < NP; p++) lookup(p, (p * 37 + 5) & 12'hfff, req);
    endtask

    function automatic void model_search(input int np, input int lg, output bit f, output int base);
        int cand = 0;
        int cnt = 0;
        int mask;
        if (lg > PW) lg = PW;
        mask = (1 << lg) - 1;
        f = 1'b0;
        base = 0;
        forever begin
            int p = cand + cnt;
            if (p >= NP) return;
            if (mdl[p] == UNM) begin
                cnt++;
                if (cnt == np) begin
                    f = 1'b1;
                    base = cand;
                    return;
                end
            end else begin
                cand = (p + 1 + mask) & ~mask;
                cnt = 0;
            end
        end
    endfunction

    task automatic run_op(input int kind, input int gpage, input logic [HW-1:0] haddr,
                          input int np, input int lg, input bit poke, input string req);
        bit is_map = kind[1];
        bit is_at  = kind[0];
        bit f = 1'b0;
        int base = 0;
        bit got = 1'b0;
        if (is_at) begin
            f = 1'b1;
            base = gpage;
            for (int i = 0; i < np; i++) begin
                int p = gpage + i;
                if (p >= NP) f = 1'b0;
                else if (mdl[p] != (is_map ? RSV : UNM)) f = 1'b0;
            end
        end
        if (!f) model_search(np, is_map ? 0 : lg, f, base);
        if (f) begin
            for (int i = 0; i < np; i++)
                mdl[base + i] = is_map ? (haddr & ~HW'(12'hfff)) + (HW'(i) << PB) : RSV;
        end
        @(negedge clk);
        op_valid      = 1'b1;
        op_kind       = 2'(kind);
        op_gaddr      = (GW'(gpage) << PB) | GW'(12'h3a5);
        op_haddr      = haddr;
        op_pages      = CW'(np);
        op_align_log2 = AW'(lg);
        @(negedge clk);
        op_valid = 1'b0;
        if (poke) begin
            // R10: request while busy must be dropped
            chk(!op_ready, "R10", "ready while busy", 64'(op_ready), 64'd0);
            op_valid = 1'b1;
            op_kind  = 2'd0;
            op_pages = CW'(1);
            @(negedge clk);
            op_valid = 1'b0;
        end
        for (int c = 0; c < 3000; c++) begin
            if (rsp_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(got, req, "response seen", 64'(got), 64'd1);
        chk(rsp_found == f && rsp_gaddr == (f ? GW'(base) << PB : GW'(0)), req, "response",
            {43'd0, rsp_found, rsp_gaddr}, {43'd0, f, (f ? GW'(base) << PB : GW'(0))});
        @(negedge clk);
        chk(op_ready && !rsp_valid, "R10", "ready after response",
            {62'd0, op_ready, rsp_valid}, 64'd2);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) mdl[p] = UNM;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(op_ready && !rsp_valid && !lk_done, "R1", "reset outputs",
            {61'd0, op_ready, rsp_valid, lk_done}, 64'd4);
        sweep("R1");
        // R5 falls back to R8: nothing reserved yet
        run_op(3, 5, 40'h00_ABCD_E123, 2, 0, 1'b0, "R5");
        sweep("R8");
        run_op(1, 20, '0, 3, 0, 1'b0, "R6");
        sweep("R3");
        run_op(3, 20, 40'h12_3456_7890, 3, 0, 1'b0, "R4");
        sweep("R4");
        run_op(0, 0, '0, 4, 2, 1'b0, "R7");
        // R6 fallback, with a stray request during the operation (R10)
        run_op(1, 2, '0, 3, 0, 1'b1, "R6");
        sweep("R10");
        run_op(0, 0, '0, 300, 0, 1'b0, "R9");
        sweep("R9");
        run_op(0, 0, '0, 128, 7, 1'b0, "R7");
        run_op(2, 0, 40'h77_0000_0000, 2, 0, 1'b0, "R8");
        run_op(0, 0, '0, 64, 6, 1'b0, "R7");
        run_op(0, 0, '0, 64, 6, 1'b0, "R9");
        run_op(0, 0, '0, 1, 15, 1'b0, "R7");
        run_op(3, 250, 40'h05_5500_0FFF, 10, 0, 1'b0, "R5");
        run_op(3, 128, 40'h09_8765_4000, 4, 0, 1'b0, "R4");
        sweep("R2");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule